// File: doc/BRIEF.md
# Shift-Register FIFO with Occupancy Address

This block is a synchronous first-in first-out buffer whose storage is a chain of registers that shift, not a RAM with separate read and write pointers. Each accepted write moves every stored word one stage deeper and loads the new word into stage zero. The oldest word therefore sits at the deepest occupied stage. One up/down counter tracks that stage, and a tap multiplexer uses it to present the oldest word at the output.

The counter is driven out as the level address. While the buffer holds words, it equals the occupancy minus one. While the buffer is empty, it is all ones. Placing the empty flag above the address bits gives a signed number that always equals occupancy minus one. Logic outside the block can derive extra thresholds from that number.

Width, depth and storage segment length are parameters. When the depth is larger than one segment, the segments are cascaded. A two-level selection then picks a stage inside each segment and after that picks the segment.

Top module: `srfifo`

## Requirements
- R1: A synchronous active-high reset drives empty to 1, full to 0 and the level address to all ones. Stored words are not cleared.
- R2: While empty is 0, the read data output carries the oldest stored word. Words leave in the order they were written.
- R3: The level address equals occupancy minus one while words are stored, and is all ones when none are stored. The value {empty, level address}, read as a signed number, equals occupancy minus one at all times.
- R4: Full is 1 exactly when the level address equals DEPTH-1 and empty is 0. Full and empty are never 1 together.
- R5: A write on its own while not full raises occupancy by one. A read on its own while not empty lowers occupancy by one.
- R6: A write and a read in the same cycle, with the buffer neither full nor empty, remove the oldest word, append the new word and leave occupancy unchanged.
- R7: A write on its own while full is ignored. Flags, level address and stored words stay unchanged.
- R8: A read on its own while empty is ignored. Empty stays 1 and the level address stays all ones.
- R9: A write and a read in the same cycle while full perform only the read. Occupancy becomes DEPTH-1 and the new word is dropped.
- R10: A write and a read in the same cycle while empty perform only the write. Occupancy becomes 1 and the output shows the new word.
- R11: When DEPTH is larger than SEG_DEPTH, every stage across the cascaded segments is reachable, so a completely filled buffer drains in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read strobe, discards the oldest word |
| rd_data | output | DW | Oldest stored word, valid while empty is 0 |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| level_addr | output | $clog2(DEPTH) | Occupancy minus one, all ones when empty |

## Verification
Full, empty and the level address are registers, so the effect of a strobe shows on them one rising edge after the strobe is sampled. The read data output is a combinational tap of the registered chain, so its new value is also due right after that same edge. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares all outputs against a queue model on the next falling edge. No result is read across two edges, and none is read in the edge where it changes.

// File: rtl/srfifo_pkg.sv
package srfifo_pkg;

    // Accepted operation in one cycle, {pop, push}
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } op_e;

    function automatic op_e decode_op(input logic push_ok, input logic pop_ok);
        return op_e'({pop_ok, push_ok});
    endfunction

    function automatic int seg_count(input int depth, input int seg);
        return (depth + seg - 1) / seg;
    endfunction

endpackage

// File: rtl/srfifo_ctrl.sv
module srfifo_ctrl
    import srfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          shift_en,
    output logic [AW-1:0] addr,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic          push_ok;
    logic          pop_ok;
    op_e           op;
    logic [AW-1:0] addr_up;
    logic [AW-1:0] addr_dn;

    always_comb begin
        push_ok  = wr_en && !full;
        pop_ok   = rd_en && !empty;
        op       = decode_op(push_ok, pop_ok);
        addr_up  = addr + AW'(1);
        addr_dn  = addr - AW'(1);
        shift_en = push_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '1;
            empty <= 1'b1;
            full  <= 1'b0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    addr  <= addr_up;
                    empty <= 1'b0;
                    full  <= (addr_up == TOP);
                end
                OP_POP: begin
                    addr  <= addr_dn;
                    empty <= (addr == '0);
                    full  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/srfifo_chain.sv
module srfifo_chain #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      shift_en,
    input  logic [DW-1:0]             din,
    output logic [DEPTH-1:0][DW-1:0]  stages
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (shift_en) stages[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (shift_en) stages[g] <= stages[g-1];
            end
        end
    end

endmodule

// File: rtl/srfifo_tapmux.sv
module srfifo_tapmux
    import srfifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int SEG   = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][DW-1:0] stages,
    input  logic [AW-1:0]            addr,
    output logic [DW-1:0]            dout
);
    localparam int NSEG = seg_count(DEPTH, SEG);
    localparam int SB   = (SEG > 1) ? $clog2(SEG) : 1;

    if (NSEG == 1) begin : g_flat
        always_comb begin
            dout = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (addr == AW'(i)) dout = stages[i];
            end
        end
    end else begin : g_tree
        localparam int HW = AW - SB;
        logic [SB-1:0]            lo;
        logic [HW-1:0]            hi;
        logic [NSEG-1:0][DW-1:0]  seg_out;

        assign lo = addr[SB-1:0];
        assign hi = addr[AW-1:SB];

        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            always_comb begin
                seg_out[s] = '0;
                for (int i = 0; i < SEG; i++) begin
                    if ((s * SEG + i < DEPTH) && (lo == SB'(i)))
                        seg_out[s] = stages[(s * SEG + i < DEPTH) ? s * SEG + i : 0];
                end
            end
        end

        always_comb begin
            dout = '0;
            for (int s = 0; s < NSEG; s++) begin
                if (hi == HW'(s)) dout = seg_out[s];
            end
        end
    end

endmodule

// File: rtl/srfifo.sv
module srfifo #(
    parameter int DW        = 8,
    parameter int DEPTH     = 16,
    parameter int SEG_DEPTH = 8,
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] level_addr
);
    logic                      shift_en;
    logic [DEPTH-1:0][DW-1:0]  stages;

    srfifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .shift_en (shift_en),
        .addr     (level_addr),
        .full     (full),
        .empty    (empty)
    );

    srfifo_chain #(.DW(DW), .DEPTH(DEPTH)) u_chain (
        .clk      (clk),
        .shift_en (shift_en),
        .din      (wr_data),
        .stages   (stages)
    );

    srfifo_tapmux #(.DW(DW), .DEPTH(DEPTH), .SEG(SEG_DEPTH), .AW(AW)) u_tap (
        .stages (stages),
        .addr   (level_addr),
        .dout   (rd_data)
    );

endmodule

// File: rtl/srfifo_checks.sv
module srfifo_checks #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic [AW-1:0] level_addr
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_q_up;
    logic [AW-1:0] addr_q_dn;

    always_ff @(posedge clk) addr_q <= level_addr;

    always_comb begin
        addr_q_up = addr_q + AW'(1);
        addr_q_dn = addr_q - AW'(1);
    end

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (empty && !full && (&level_addr)));

    // R3
    a_r3_empty_all_ones: assert property (@(posedge clk) disable iff (rst)
        empty |-> (&level_addr));

    // R4
    a_r4_full_at_top: assert property (@(posedge clk) disable iff (rst)
        full |-> (!empty && level_addr == AW'(DEPTH - 1)));

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R5
    a_r5_push_counts_up: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && !full) |=> (level_addr == addr_q_up && !empty));

    a_r5_pop_counts_down: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !empty) |=> (level_addr == addr_q_dn && !full));

    // R6
    a_r6_swap_holds_level: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && !empty && !full) |=> $stable(level_addr));

    // R7
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && $stable(level_addr)));

    // R8
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(level_addr)));

    // R9
    a_r9_full_swap_reads: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_en) |=> (!full && level_addr == AW'(DEPTH - 2)));

    // R10
    a_r10_empty_swap_writes: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en && rd_en) |=> (!empty && level_addr == '0));

endmodule

bind srfifo srfifo_checks #(.DEPTH(DEPTH), .AW(AW)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .full       (full),
    .empty      (empty),
    .level_addr (level_addr)
);

// File: tb/srfifo_bench.sv
`timescale 1ns/1ps
module srfifo_bench;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    // table entry: {wr, rd, expected occupancy after the cycle}
    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] occ;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'd1},   // R5 push
        '{1'b1, 1'b0, 8'd2},   // R5 push
        '{1'b1, 1'b1, 8'd2},   // R6 swap
        '{1'b0, 1'b1, 8'd1},   // R5 pop
        '{1'b0, 1'b1, 8'd0},   // R5 pop to empty
        '{1'b0, 1'b1, 8'd0},   // R8 read while empty
        '{1'b1, 1'b1, 8'd1},   // R10 swap while empty
        '{1'b1, 1'b0, 8'd2},
        '{1'b0, 1'b0, 8'd2},   // idle
        '{1'b1, 1'b1, 8'd2},   // R6
        '{1'b0, 1'b1, 8'd1},
        '{1'b0, 1'b1, 8'd0}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [DW-1:0] rd_data;
    logic          full;
    logic          empty;
    logic [AW-1:0] level_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    logic [DW-1:0] model [$];

    always #2 clk = ~clk;

    srfifo #(.DW(DW), .DEPTH(DEPTH), .SEG_DEPTH(8)) u_srfifo (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .full       (full),
        .empty      (empty),
        .level_addr (level_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        int occ;
        occ = model.size();
        check(empty == (occ == 0), req, "empty", int'(empty), int'(occ == 0));
        check(full == (occ == DEPTH), req, "full", int'(full), int'(occ == DEPTH));
        check(level_addr == ((occ == 0) ? {AW{1'b1}} : AW'(occ - 1)), req,
              "level_addr", int'(level_addr), (occ == 0) ? (1 << AW) - 1 : occ - 1);
        check(int'($signed({empty, level_addr})) == occ - 1, req, "signed level",
              int'($signed({empty, level_addr})), occ - 1);
        if (occ > 0)
            check(rd_data == model[0], req, "rd_data", int'(rd_data), int'(model[0]));
    endtask

    // drive on falling edge, one rising edge, check on next falling edge
    task automatic step(input bit w, input bit r, input logic [DW-1:0] d, input string req);
        bit wa;
        bit ra;
        wr_en   = w;
        rd_en   = r;
        wr_data = d;
        wa = w && (model.size() < DEPTH);
        ra = r && (model.size() > 0);
        @(posedge clk);
        if (ra) void'(model.pop_front());
        if (wa) model.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check_state(req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        model.delete();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; rst = 1'b1;
        @(negedge clk);
        do_reset();
        check_state("R1");

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            step(VECS[k].wr, VECS[k].rd, DW'(8'hA0 + k), "R3");
            check(model.size() == int'(VECS[k].occ), "R5", "table occupancy",
                  model.size(), int'(VECS[k].occ));
        end

        // fill across both segments
        for (int k = 0; k < DEPTH; k++) step(1'b1, 1'b0, DW'(8'h10 + k), "R4");
        check(full == 1'b1, "R4", "full after fill", int'(full), 1);

        // write while full ignored
        step(1'b1, 1'b0, 8'hEE, "R7");
        step(1'b1, 1'b0, 8'hEF, "R7");

        // simultaneous while full: read only
        step(1'b1, 1'b1, 8'hDD, "R9");
        step(1'b1, 1'b0, 8'h77, "R5");

        // drain in order across segments
        for (int k = 0; k < DEPTH; k++) step(1'b0, 1'b1, 8'h00, "R11");
        step(1'b0, 1'b1, 8'h00, "R8");
        step(1'b1, 1'b1, 8'h55, "R10");
        step(1'b1, 1'b1, 8'h56, "R6");
        step(1'b1, 1'b1, 8'h57, "R2");

        // reset while holding words
        step(1'b1, 1'b0, 8'h58, "R5");
        do_reset();
        check_state("R1");

        // random traffic, biased to hit both boundaries
        for (int k = 0; k < 3000; k++) begin
            int bias;
            bias = ((k / 200) % 2 == 0) ? 75 : 25;
            step(($urandom % 100) < bias, ($urandom % 100) < (100 - bias),
                 DW'($urandom), "R2");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule